// File: doc/BRIEF.md
# Automatic Flow-Control Character Inserter

This block sits in front of a serial transmitter. It watches how full the receive FIFO is and, when the fill count rises above a programmed trigger, it slips a "stop sending" character into the transmit stream. A UART peer that honours software flow control then pauses. Once the fill count falls below the trigger again, the block sends a "resume" character. The stop and resume messages are either one character or a pair of characters. A pair always goes out back to back. Inserted characters are trimmed to the programmed word length. They take precedence over user data at the next character boundary.

User data flows through a valid/ready stream (`usr_*`) to the transmitter stream (`tx_*`). A character moves when valid and ready are both high at a rising clock edge. While valid is high and ready is low, the offered character and its valid must hold until the transfer completes. The block keeps that rule on `tx_*` for its own characters and for user characters alike. A user character already on offer is never displaced by an insertion. When no insertion is due, `usr_ready` follows `tx_ready`. While an insertion is on offer, `usr_ready` is low.

Top module: `fcx_inserter`

## Requirements
- R1: After reset `remote_paused` is 0 and the block is transparent: `tx_valid`=`usr_valid`, `tx_data`=`usr_data`, `usr_ready`=`tx_ready`.
- R2: With `cfg_enable`=1, `remote_paused`=0 and `rx_level` > `rx_trigger`, the next character offered on `tx_*` is `cfg_stop_a`. `remote_paused` becomes 1 on the clock edge after that offer first appears.
- R3: With `cfg_double`=1, the transfer of `cfg_stop_a` is followed at once by `cfg_stop_b`, and the transfer of `cfg_go_a` is followed at once by `cfg_go_b`, with no user character between them. With `cfg_double`=0, only the first character of each pair is sent.
- R4: With `cfg_enable`=1, `remote_paused`=1 and `rx_level` < `rx_trigger`, the next character offered is `cfg_go_a`. `remote_paused` returns to 0 on the clock edge after that offer first appears.
- R5: `rx_level` equal to `rx_trigger` changes nothing. Only one stop message is sent per pause, however long the level stays high.
- R6: With `cfg_enable`=0, no character is inserted. `remote_paused` is cleared at the next edge that falls between sequences.
- R7: Once any character is offered on `tx_*` without being taken, `tx_valid` stays 1 and `tx_data` stays the same until it is taken. A user character already on offer is sent before any insertion.
- R8: Inserted characters keep the low 5, 6, 7 or 8 bits for `cfg_wlen` = 0, 1, 2 or 3, and the upper bits are driven 0. User data is not altered.
- R9: If the level falls below the trigger while a stop message is still being sent, the resume message follows it directly, ahead of waiting user data.
- R10: While an inserted character is on offer, `usr_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Enables automatic insertion |
| cfg_double | input | 1 | 1: two-character messages, 0: one character |
| cfg_wlen | input | 2 | Word length code, 0..3 = 5..8 bits |
| cfg_stop_a | input | 8 | First stop character |
| cfg_stop_b | input | 8 | Second stop character |
| cfg_go_a | input | 8 | First resume character |
| cfg_go_b | input | 8 | Second resume character |
| rx_level | input | LVL_W | Receive FIFO fill count |
| rx_trigger | input | LVL_W | Trigger threshold |
| usr_valid | input | 1 | User character offered |
| usr_data | input | 8 | User character |
| usr_ready | output | 1 | User character accepted this cycle |
| tx_valid | output | 1 | Character offered to the transmitter |
| tx_data | output | 8 | Character to the transmitter |
| tx_ready | input | 1 | Transmitter free at a character boundary |
| remote_paused | output | 1 | Stop message sent and not yet cancelled |

## Verification
The bench holds the transmitter off while a stop character is on offer. It then drops the level below the trigger, so the stop pair and the resume pair must come out as four consecutive characters. A design that split the pair, or that let a waiting user character slip in, would show a user byte inside that run. It keeps the level exactly at the trigger for many cycles. A design that compared with the wrong inequality, or that re-armed the stop message, would emit extra stop characters there. Narrow word lengths and disable-while-paused are driven directly. Long random stretches with random stalls catch any change of the offered character before it is taken.

// File: rtl/fcx_pkg.sv
package fcx_pkg;
  localparam int CHAR_W = 8;

  typedef enum logic [2:0] {
    LN_USER = 3'd0,
    LN_OFF1 = 3'd1,
    LN_OFF2 = 3'd2,
    LN_ON1  = 3'd3,
    LN_ON2  = 3'd4
  } lane_e;

  function automatic logic [CHAR_W-1:0] wlen_mask(input logic [1:0] wl);
    logic [CHAR_W-1:0] m;
    m = '0;
    for (int i = 0; i < CHAR_W; i++) begin
      if (i < 5 + int'(wl)) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/fcx_level_cmp.sv
module fcx_level_cmp #(
  parameter int LVL_W = 7
) (
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] trigger,
  output logic             over,
  output logic             under
);
  always_comb begin
    over  = level > trigger;
    under = level < trigger;
  end
endmodule

// File: rtl/fcx_seq_fsm.sv
module fcx_seq_fsm
  import fcx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  logic  dbl,
  input  logic  over,
  input  logic  under,
  input  logic  usr_valid,
  input  logic  tx_ready,
  output lane_e lane,
  output logic  paused
);
  lane_e state_q, state_d;
  logic  hold_q, hold_d;
  logic  paused_d;
  logic  acc;

  // lane choice: a running sequence keeps its lane; between sequences a
  // pending user offer wins, then stop, then resume
  always_comb begin
    lane = state_q;
    if (state_q == LN_USER) begin
      if (hold_q)                     lane = LN_USER;
      else if (en && !paused && over) lane = LN_OFF1;
      else if (en && paused && under) lane = LN_ON1;
      else                            lane = LN_USER;
    end
  end

  always_comb begin
    acc = tx_ready && ((lane != LN_USER) || usr_valid);
    unique case (lane)
      LN_OFF1: state_d = acc ? (dbl ? LN_OFF2 : LN_USER) : LN_OFF1;
      LN_OFF2: state_d = acc ? LN_USER : LN_OFF2;
      LN_ON1:  state_d = acc ? (dbl ? LN_ON2 : LN_USER) : LN_ON1;
      LN_ON2:  state_d = acc ? LN_USER : LN_ON2;
      default: state_d = LN_USER;
    endcase
    hold_d = (lane == LN_USER) && usr_valid && !tx_ready;
    paused_d = paused;
    if (state_q == LN_USER) begin
      if (lane == LN_OFF1)     paused_d = 1'b1;
      else if (lane == LN_ON1) paused_d = 1'b0;
      else if (!en)            paused_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= LN_USER;
      hold_q  <= 1'b0;
      paused  <= 1'b0;
    end else begin
      state_q <= state_d;
      hold_q  <= hold_d;
      paused  <= paused_d;
    end
  end
endmodule

// File: rtl/fcx_tx_mux.sv
module fcx_tx_mux
  import fcx_pkg::*;
(
  input  lane_e             lane,
  input  logic [1:0]        wlen,
  input  logic [CHAR_W-1:0] stop_a,
  input  logic [CHAR_W-1:0] stop_b,
  input  logic [CHAR_W-1:0] go_a,
  input  logic [CHAR_W-1:0] go_b,
  input  logic              usr_valid,
  input  logic [CHAR_W-1:0] usr_data,
  input  logic              tx_ready,
  output logic              usr_ready,
  output logic              tx_valid,
  output logic [CHAR_W-1:0] tx_data
);
  logic [CHAR_W-1:0] mask;
  logic [CHAR_W-1:0] ctl;

  always_comb begin
    mask = wlen_mask(wlen);
    unique case (lane)
      LN_OFF1: ctl = stop_a;
      LN_OFF2: ctl = stop_b;
      LN_ON1:  ctl = go_a;
      LN_ON2:  ctl = go_b;
      default: ctl = '0;
    endcase
    if (lane == LN_USER) begin
      tx_valid  = usr_valid;
      tx_data   = usr_data;
      usr_ready = tx_ready;
    end else begin
      tx_valid  = 1'b1;
      tx_data   = ctl & mask;
      usr_ready = 1'b0;
    end
  end
endmodule

// File: rtl/fcx_inserter.sv
module fcx_inserter
  import fcx_pkg::*;
#(
  parameter int LVL_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic              cfg_double,
  input  logic [1:0]        cfg_wlen,
  input  logic [CHAR_W-1:0] cfg_stop_a,
  input  logic [CHAR_W-1:0] cfg_stop_b,
  input  logic [CHAR_W-1:0] cfg_go_a,
  input  logic [CHAR_W-1:0] cfg_go_b,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic [LVL_W-1:0]  rx_trigger,
  input  logic              usr_valid,
  input  logic [CHAR_W-1:0] usr_data,
  output logic              usr_ready,
  output logic              tx_valid,
  output logic [CHAR_W-1:0] tx_data,
  input  logic              tx_ready,
  output logic              remote_paused
);
  logic  over, under;
  lane_e lane;

  fcx_level_cmp #(.LVL_W(LVL_W)) u_cmp (
    .level   (rx_level),
    .trigger (rx_trigger),
    .over    (over),
    .under   (under)
  );

  fcx_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (cfg_enable),
    .dbl       (cfg_double),
    .over      (over),
    .under     (under),
    .usr_valid (usr_valid),
    .tx_ready  (tx_ready),
    .lane      (lane),
    .paused    (remote_paused)
  );

  fcx_tx_mux u_mux (
    .lane      (lane),
    .wlen      (cfg_wlen),
    .stop_a    (cfg_stop_a),
    .stop_b    (cfg_stop_b),
    .go_a      (cfg_go_a),
    .go_b      (cfg_go_b),
    .usr_valid (usr_valid),
    .usr_data  (usr_data),
    .tx_ready  (tx_ready),
    .usr_ready (usr_ready),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data)
  );
endmodule

// File: rtl/fcx_checker.sv
module fcx_checker
  import fcx_pkg::*;
#(
  parameter int LVL_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_enable,
  input logic              cfg_double,
  input logic [1:0]        cfg_wlen,
  input logic [LVL_W-1:0]  rx_level,
  input logic [LVL_W-1:0]  rx_trigger,
  input logic              usr_ready,
  input logic              tx_valid,
  input logic [CHAR_W-1:0] tx_data,
  input logic              tx_ready,
  input logic              remote_paused,
  input lane_e             lane
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R7

  AST_PAUSE_ON_OVER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(remote_paused) |-> ($past(cfg_enable) && $past(rx_level > rx_trigger))); // R2

  AST_RESUME_COND: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(remote_paused) |-> (!$past(cfg_enable) || $past(rx_level < rx_trigger))); // R4

  AST_PAIR_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (lane == LN_OFF1 && tx_ready && cfg_double) |=> (lane == LN_OFF2)); // R3

  AST_INSERT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (lane != LN_USER) |-> ((tx_data & ~wlen_mask(cfg_wlen)) == '0)); // R8

  AST_USER_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (lane != LN_USER) |-> (!usr_ready && tx_valid)); // R10
endmodule

bind fcx_inserter fcx_checker #(.LVL_W(LVL_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_enable    (cfg_enable),
  .cfg_double    (cfg_double),
  .cfg_wlen      (cfg_wlen),
  .rx_level      (rx_level),
  .rx_trigger    (rx_trigger),
  .usr_ready     (usr_ready),
  .tx_valid      (tx_valid),
  .tx_data       (tx_data),
  .tx_ready      (tx_ready),
  .remote_paused (remote_paused),
  .lane          (lane)
);

// File: tb/tb_fcx_inserter.sv
`timescale 1ns/1ps
module tb_fcx_inserter;
  localparam int LVL_W = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_enable = 1'b0, cfg_double = 1'b0;
  logic [1:0] cfg_wlen = 2'd3;
  logic [7:0] cfg_stop_a = 8'h13, cfg_stop_b = 8'h93, cfg_go_a = 8'h11, cfg_go_b = 8'h91;
  logic [LVL_W-1:0] rx_level = '0, rx_trigger = 7'd32;
  logic usr_valid = 1'b0;
  logic [7:0] usr_data = 8'h00;
  logic usr_ready, tx_valid, tx_ready = 1'b0, remote_paused;
  logic [7:0] tx_data;

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  int m_state = 0;
  bit m_paused = 0, m_hold = 0;
  logic [7:0] log_q [0:15];
  int log_n = 0;
  bit took_usr = 0;

  always #2.5 clk = ~clk;

  fcx_inserter #(.LVL_W(LVL_W)) dut (.*);

  function automatic logic [7:0] mask_of(input logic [1:0] wl);
    case (wl)
      2'd0: return 8'h1F;
      2'd1: return 8'h3F;
      2'd2: return 8'h7F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] char_of(input int ln);
    case (ln)
      1: return cfg_stop_a & mask_of(cfg_wlen);
      2: return cfg_stop_b & mask_of(cfg_wlen);
      3: return cfg_go_a & mask_of(cfg_wlen);
      4: return cfg_go_b & mask_of(cfg_wlen);
      default: return usr_data;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one clock cycle: compare outputs with the reference, then advance it
  task automatic cyc();
    int el;
    bit ev, eur, acc;
    logic [7:0] ed;
    string tag;
    #1;
    took_usr = 0;
    if (!rst_n) begin
      m_state = 0; m_paused = 0; m_hold = 0;
    end else begin
      if (m_state != 0) el = m_state;
      else if (m_hold) el = 0;
      else if (cfg_enable && !m_paused && rx_level > rx_trigger) el = 1;
      else if (cfg_enable && m_paused && rx_level < rx_trigger) el = 3;
      else el = 0;
      ev = (el != 0) ? 1'b1 : usr_valid;
      ed = char_of(el);
      eur = (el == 0) && tx_ready;
      case (el)
        1: tag = "R2 stop";
        2: tag = "R3 stop pair";
        3, 4: tag = "R4 resume";
        default: tag = "R7 user lane";
      endcase
      chk(tx_valid == ev && (!ev || tx_data == ed) && usr_ready == eur && remote_paused == m_paused,
          tag, {20'd0, tx_valid, tx_data, usr_ready, remote_paused},
          {20'd0, ev, (ev ? ed : tx_data), eur, m_paused});
      acc = ev && tx_ready;
      if (acc && log_n < 16) begin log_q[log_n] = tx_data; log_n++; end
      if (acc && el == 0) took_usr = 1;
      if (m_state == 0) begin
        if (el == 1) m_paused = 1;
        else if (el == 3) m_paused = 0;
        else if (!cfg_enable) m_paused = 0;
      end
      case (el)
        1: m_state = acc ? (cfg_double ? 2 : 0) : 1;
        3: m_state = acc ? (cfg_double ? 4 : 0) : 3;
        2, 4: m_state = acc ? 0 : el;
        default: m_state = 0;
      endcase
      m_hold = (el == 0) && usr_valid && !tx_ready;
    end
    @(negedge clk);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    run(3);
    rst_n = 1'b1;
    log_n = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: reset state and transparency
    usr_valid = 1; usr_data = 8'h55; tx_ready = 1; cfg_enable = 1; rx_level = 7'd10;
    do_reset();
    #1;
    chk(remote_paused == 0, "R1 paused after reset", remote_paused, 0);
    chk(tx_valid && tx_data == 8'h55 && usr_ready, "R1 transparent", {tx_valid, tx_data, usr_ready}, {1'b1, 8'h55, 1'b1});
    @(negedge clk);

    // single mode: stop once, hold at trigger, resume (R2 R5 R4)
    cfg_double = 0; rx_trigger = 7'd32; rx_level = 7'd40;
    run(3);
    chk(log_q[0] == 8'h13 && log_q[1] == 8'h55 && log_q[2] == 8'h55, "R2 single stop then user",
        {log_q[0], log_q[1], log_q[2]}, {8'h13, 8'h55, 8'h55});
    rx_level = 7'd32; log_n = 0;
    run(20);
    chk(log_n == 16 && log_q[15] == 8'h55 && remote_paused, "R5 no repeat stop at trigger",
        {log_n[7:0], log_q[15], 7'd0, remote_paused}, {8'd16, 8'h55, 8'd1});
    rx_level = 7'd50; log_n = 0;
    run(5);
    chk(log_q[0] == 8'h55 && log_q[4] == 8'h55, "R5 once per pause", {log_q[0], log_q[4]}, {8'h55, 8'h55});
    rx_level = 7'd5; log_n = 0;
    run(3);
    chk(log_q[0] == 8'h11 && log_q[1] == 8'h55 && !remote_paused, "R4 single resume",
        {log_q[0], log_q[1], 7'd0, remote_paused}, {8'h11, 8'h55, 8'd0});

    // double mode with stall and queued resume (R3 R7 R9)
    cfg_double = 1; do_reset();
    tx_ready = 0; rx_level = 7'd40;
    run(4);
    chk(tx_valid && tx_data == 8'h13 && !usr_ready, "R10 stalled stop blocks user",
        {tx_valid, tx_data, usr_ready}, {1'b1, 8'h13, 1'b0});
    rx_level = 7'd3; tx_ready = 1;
    run(6);
    chk(log_q[0] == 8'h13 && log_q[1] == 8'h93 && log_q[2] == 8'h11 && log_q[3] == 8'h91 && log_q[4] == 8'h55,
        "R9 R3 stop pair then resume pair",
        {log_q[0], log_q[1], log_q[2], log_q[3]}, {8'h13, 8'h93, 8'h11, 8'h91});

    // user offer pending when level crosses (R7)
    do_reset();
    tx_ready = 0; rx_level = 7'd10;
    run(2);
    rx_level = 7'd60;
    run(2);
    chk(tx_data == 8'h55, "R7 pending user kept", tx_data, 8'h55);
    tx_ready = 1;
    run(2);
    chk(log_q[0] == 8'h55 && log_q[1] == 8'h13, "R7 user first then stop", {log_q[0], log_q[1]}, {8'h55, 8'h13});

    // disabled (R6)
    cfg_enable = 0; do_reset();
    rx_level = 7'd100;
    run(10);
    chk(log_n == 10 && log_q[9] == 8'h55 && !remote_paused, "R6 no insert when disabled",
        {log_n[7:0], log_q[9]}, {8'd10, 8'h55});
    cfg_enable = 1; cfg_double = 0;
    run(3);
    chk(remote_paused, "R2 paused after enable", remote_paused, 1);
    cfg_enable = 0;
    run(1);
    chk(!remote_paused, "R6 paused cleared on disable", remote_paused, 0);

    // word length masking (R8)
    cfg_enable = 1; cfg_wlen = 2'd0; cfg_stop_a = 8'hE5; cfg_go_a = 8'hFA; do_reset();
    rx_level = 7'd90;
    run(2);
    rx_level = 7'd0;
    run(2);
    chk(log_q[0] == 8'h05 && log_q[2] == 8'h1A, "R8 five-bit masking", {log_q[0], log_q[2]}, {8'h05, 8'h1A});
    cfg_wlen = 2'd2; cfg_stop_a = 8'hFF; do_reset();
    rx_level = 7'd90;
    run(2);
    chk(log_q[0] == 8'h7F, "R8 seven-bit masking", log_q[0], 8'h7F);

    // constrained random blocks, checked every cycle by the reference
    void'($urandom(32'd1234));
    for (int b = 0; b < 12; b++) begin
      cfg_enable = ($urandom % 5) != 0;
      cfg_double = $urandom % 2;
      cfg_wlen = 2'($urandom % 4);
      cfg_stop_a = 8'($urandom); cfg_stop_b = 8'($urandom);
      cfg_go_a = 8'($urandom); cfg_go_b = 8'($urandom);
      rx_trigger = 7'(1 + $urandom % 62);
      usr_valid = 0;
      do_reset();
      for (int i = 0; i < 1500; i++) begin
        if (took_usr || !usr_valid) begin
          usr_valid = ($urandom % 4) != 0;
          usr_data = 8'($urandom);
        end
        tx_ready = ($urandom % 3) != 0;
        if ($urandom % 6 == 0) begin
          if ($urandom % 4 == 0) rx_level = 7'($urandom % 128);
          else rx_level = 7'(int'(rx_trigger) + int'($urandom % 5) - 2);
        end
        cyc();
      end
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule